// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This block holds the program counter of a single-cycle processor and supplies the instruction word stored at that address. The instruction store is a read-only array inside the block. It is read combinationally, so the word for the current PC is on the output in the same cycle as the PC, with no clock involved in the read.

On every rising clock edge the PC advances. It normally moves to the next word, PC + 4. A conditional branch moves it instead to PC + 4 plus the 16-bit immediate, sign-extended and scaled by four. The branch is taken only when the decoder's branch select and the datapath's operand-equality flag are both high in that cycle. All address arithmetic is modulo 2^32. A synchronous active-low reset returns the PC to zero.

Top module: `ifu_fetch_unit`

## Requirements
- R1: When rst_n is low at a rising clock edge, pc_o is 0 after that edge, whatever the other inputs are.
- R2: pc_o[1:0] is always 2'b00.
- R3: When rst_n is high and br_sel is low at a rising edge, pc_o after the edge is the old pc_o + 4 (mod 2^32).
- R4: When br_sel is high but eq_flag is low at an edge, pc_o still advances by exactly 4.
- R5: When br_sel and eq_flag are both high at an edge, pc_o after the edge is old pc_o + 4 + (sign-extended imm16 << 2), with bit 15 of imm16 as the sign.
- R6: A negative offset that carries the PC below zero wraps modulo 2^32 (from PC 4 with imm16 = 16'hFFFC the next PC is 32'hFFFFFFF8). Sequential flow from 32'hFFFFFFFC wraps to 0.
- R7: instr_o is combinational and equals ROM word k = ((k * 32'h9E3779B9) mod 2^32) XOR ROM_SEED, where k = pc_o[31:2] mod ROM_WORDS. Addresses beyond the array alias into it.
- R8: eq_flag and imm16 have no effect on pc_o while br_sel is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| br_sel | input | 1 | Branch select from the decoder |
| eq_flag | input | 1 | Operand-equality flag from the datapath |
| imm16 | input | 16 | Immediate field of the current instruction |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word at the current PC |

## Verification
The bench builds the block with ROM_WORDS = 16 and ROM_SEED = 32'h1234_5678. The small array makes aliasing reachable at the top of the address space: a backward branch that wraps to 32'hFFFFFFF8 must read word 14, and the sequential wrap to 0 must read word 0. The non-default seed shows that the seed is applied to every stored word. Under these values the largest forward and backward immediates, the wrap below zero, and a reset taken from a non-zero PC are each a few cycles from reset.

// File: rtl/ifu_pkg.sv
// Package for the fetch unit: shared widths and the ROM content generator.
// Assumes instruction words and addresses are both 32 bits wide.
package ifu_pkg;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] ROM_MULT = 32'h9E37_79B9;

    typedef logic [WORD_W-1:0] word_t;

    // Content of ROM word k: a multiplicative hash of its index, mixed with a seed.
    function automatic word_t rom_word(input int unsigned k, input word_t seed);
        word_t idx;
        idx = word_t'(k);
        return (idx * ROM_MULT) ^ seed;
    endfunction

endpackage

// File: rtl/ifu_rom.sv
// Instruction ROM: a combinational word-indexed read-only array.
// Assumes DEPTH is a power of two; the index is already reduced to IDX_W bits.
module ifu_rom #(
    parameter int unsigned DEPTH = 256,
    parameter logic [31:0] SEED  = 32'h0,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] idx,
    output ifu_pkg::word_t   word
);

    ifu_pkg::word_t mem [DEPTH];

    // Fill each entry with its constant content.
    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        assign mem[i] = ifu_pkg::rom_word(i, SEED);
    end

    // Read path: purely combinational, no clock.
    always_comb begin
        word = mem[idx];
    end

endmodule

// File: rtl/ifu_next_pc.sv
// Next-address logic: selects PC+4 or the branch target.
// Assumes the immediate is a word offset relative to PC+4; all sums wrap.
module ifu_next_pc #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IMM_W = 16,
    localparam int unsigned EXT_W = PC_W - IMM_W - 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             br_sel,
    input  logic             eq_flag,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  pc_next
);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] offset;
    logic [PC_W-1:0] target;
    logic            taken;

    // Sequential successor, branch offset and branch target.
    always_comb begin
        seq_pc = pc + PC_W'(4);
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        target = seq_pc + offset;
    end

    // Select the successor; the branch needs both the select and the flag.
    always_comb begin
        taken   = br_sel & eq_flag;
        pc_next = taken ? target : seq_pc;
    end

endmodule

// File: rtl/ifu_pc_reg.sv
// Program counter register with synchronous active-low reset to zero.
// Assumes every value written to it is word aligned.
module ifu_pc_reg #(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] d,
    output logic [PC_W-1:0] q
);

    // Capture the next PC every edge; reset wins.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/ifu_fetch_unit.sv
// Fetch unit top: PC register, next-address logic and instruction ROM.
// Assumes ROM_WORDS is a power of two; the ROM aliases higher addresses.
module ifu_fetch_unit #(
    parameter int unsigned ROM_WORDS = 256,
    parameter logic [31:0] ROM_SEED  = 32'h0,
    localparam int unsigned PC_W  = 32,
    localparam int unsigned IMM_W = 16,
    localparam int unsigned IDX_W = $clog2(ROM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_sel,
    input  logic             eq_flag,
    input  logic [IMM_W-1:0] imm16,
    output logic [PC_W-1:0]  pc_o,
    output logic [31:0]      instr_o
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;

    ifu_next_pc #(.PC_W(PC_W), .IMM_W(IMM_W)) u_next (
        .pc      (pc_q),
        .br_sel  (br_sel),
        .eq_flag (eq_flag),
        .imm     (imm16),
        .pc_next (pc_d)
    );

    ifu_pc_reg #(.PC_W(PC_W)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pc_d),
        .q     (pc_q)
    );

    ifu_rom #(.DEPTH(ROM_WORDS), .SEED(ROM_SEED)) u_rom (
        .idx  (pc_q[IDX_W+1:2]),
        .word (instr_o)
    );

    assign pc_o = pc_q;

    // R1
    pc_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0));

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);

    // R3 R4 R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_sel && eq_flag) |=> (pc_q == $past(pc_q) + 32'd4));

    // R5 R6
    pc_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && eq_flag) |=>
        (pc_q == $past(pc_q) + 32'd4 + {{14{$past(imm16[15])}}, $past(imm16), 2'b00}));

endmodule

// File: tb/ifu_fetch_unit_tb.sv
// Directed bench for the fetch unit; each scenario task checks its own results.
module ifu_fetch_unit_tb_top;

    localparam int unsigned NW   = 16;
    localparam logic [31:0] SEED = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_sel = 1'b0;
    logic        eq_flag = 1'b0;
    logic [15:0] imm16 = 16'h0;
    logic [31:0] pc_o;
    logic [31:0] instr_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_pc = 32'h0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ifu_fetch_unit #(.ROM_WORDS(NW), .ROM_SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .br_sel(br_sel), .eq_flag(eq_flag),
        .imm16(imm16), .pc_o(pc_o), .instr_o(instr_o)
    );

    function automatic logic [31:0] exp_word(input logic [31:0] pc);
        logic [31:0] k;
        k = (pc >> 2) % NW;
        return (k * 32'h9E37_79B9) ^ SEED;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(pc_o == exp_pc, tag, pc_o, exp_pc);
        chk(pc_o[1:0] == 2'b00, "R2 alignment", {30'h0, pc_o[1:0]}, 32'h0);
        chk(instr_o == exp_word(exp_pc), "R7 rom word", instr_o, exp_word(exp_pc));
    endtask

    // One clock with given controls; model updated, state checked 2 ns after the edge.
    task automatic cyc(input bit b, input bit e, input logic [15:0] imm, input string tag);
        br_sel = b; eq_flag = e; imm16 = imm;
        if (b && e) exp_pc = exp_pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
        else        exp_pc = exp_pc + 32'd4;
        @(posedge clk); #2;
        check_state(tag);
    endtask

    task automatic t_reset(input bit b, input bit e);
        rst_n = 1'b0; br_sel = b; eq_flag = e; imm16 = 16'h7FFF;
        @(posedge clk); #2;
        exp_pc = 32'h0;
        check_state("R1 reset to zero");
        rst_n = 1'b1;
    endtask

    task automatic t_sequential;
        cyc(1'b0, 1'b0, 16'h0000, "R3 sequential");
        cyc(1'b0, 1'b1, 16'h0040, "R8 eq ignored without select");
        cyc(1'b0, 1'b1, 16'hFFFF, "R8 imm ignored without select");
        cyc(1'b0, 1'b0, 16'h1234, "R3 sequential");
    endtask

    task automatic t_not_equal;
        cyc(1'b1, 1'b0, 16'h0010, "R4 select without equal");
        cyc(1'b1, 1'b0, 16'hFFF0, "R4 select without equal");
    endtask

    task automatic t_forward;
        cyc(1'b1, 1'b1, 16'h0003, "R5 forward branch");
        cyc(1'b1, 1'b1, 16'h7FFF, "R5 largest forward offset");
        cyc(1'b1, 1'b1, 16'h8000, "R5 largest backward offset");
        cyc(1'b1, 1'b1, 16'hFFFF, "R5 offset -1 word");
    endtask

    task automatic t_backward_wrap;
        t_reset(1'b0, 1'b0);
        cyc(1'b0, 1'b0, 16'h0000, "R3 step to 4");
        cyc(1'b1, 1'b1, 16'hFFFC, "R6 wrap below zero");
        chk(pc_o == 32'hFFFF_FFF8, "R6 wrap value", pc_o, 32'hFFFF_FFF8);
        chk(instr_o == exp_word(32'h38), "R7 alias word 14", instr_o, exp_word(32'h38));
        cyc(1'b0, 1'b0, 16'h0000, "R3 step to top");
        cyc(1'b0, 1'b0, 16'h0000, "R6 sequential wrap to zero");
        chk(pc_o == 32'h0, "R6 wrap to zero", pc_o, 32'h0);
    endtask

    task automatic t_reset_midway;
        cyc(1'b1, 1'b1, 16'h0100, "R5 move away from zero");
        t_reset(1'b1, 1'b1);
    endtask

    initial begin
        t_reset(1'b0, 1'b0);
        t_sequential();
        t_not_equal();
        t_forward();
        t_backward_wrap();
        t_reset_midway();
        cyc(1'b0, 1'b0, 16'h0000, "R3 after reset");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired pc=%h", pc_o);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule